// File: doc/BRIEF.md
# Light-Load Switching Period Controller

This block governs the length of each switching period of a valley-switching flyback controller once load is light. In foldback operation, the sixth-valley event does not start the next cycle at once. A dead time is timed first, and it grows as the feedback level falls. A period timer watches for periods that stretch past the minimum-frequency limit. It then forces a new cycle, but only once the transformer has finished demagnetizing, so a forced cycle can never enter continuous conduction. Below a low feedback level, a hysteretic skip gate stops all cycle starts until feedback recovers.

The feedback level arrives as an unsigned value in millivolts. The surrounding controller reports whether foldback is active, when the sixth valley is seen, and whether demagnetization is complete. It also sends a strobe each time a switching cycle actually begins. The block returns a one-cycle start request and a skip flag. With the default parameters and a 100 MHz clock, one clock cycle is 10 ns, so 200 cycles is 2 us and 4000 cycles is 40 us.

Top module: `llp_ctrl`

## Requirements
- R1: After reset, start_req_o and skip_o are both 0.
- R2: When skip_o is 0 and fb_mv_i is below 400, skip_o is 1 after the next clock edge. A value of exactly 400 does not enter skip.
- R3: While skip_o is 1, it stays 1 as long as fb_mv_i is 450 or less. It falls to 0 on the edge after fb_mv_i exceeds 450.
- R4: While skip_o is 1, no start request is issued, whatever the valley, demagnetization or timer state. The period timer is held at zero, so after skip ends a clamp request with demagnetization done comes 4001 cycles after the edge that clears skip_o.
- R5: With ff_mode_i at 1 and fb_mv_i at 800 or more, a valley6_i pulse sampled at clock edge e gives start_req_o = 1 after edge e+200.
- R6: Below 800 mV the dead time in cycles is 200 + 10*(800 - fb_mv_i), capped at 4000. The value of fb_mv_i is sampled at the valley edge.
- R7: A valley6_i pulse while ff_mode_i is 0 starts no dead time and produces no request.
- R8: If no cycle_start_i arrives for 4000 cycles and demag_done_i is 1, start_req_o is 1 after the 4001st edge counted from the edge that sampled the last cycle_start_i.
- R9: Once the period limit is reached, no clamp request is issued while demag_done_i is 0. The request follows on the edge after demag_done_i rises.
- R10: start_req_o is a single-cycle pulse. At most one is issued between consecutive cycle_start_i strobes.
- R11: cycle_start_i restarts the period timer and cancels any dead time in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fb_mv_i | input | 12 | Feedback level in millivolts, unsigned |
| ff_mode_i | input | 1 | Foldback operation active |
| valley6_i | input | 1 | Single-cycle pulse: sixth valley detected |
| demag_done_i | input | 1 | Transformer demagnetization complete |
| cycle_start_i | input | 1 | Single-cycle strobe: a switching cycle has begun |
| start_req_o | output | 1 | Single-cycle request to begin a switching cycle |
| skip_o | output | 1 | Pulsing suspended by the skip gate |

## Verification
The hardest state to reach is a period timer that has hit its limit while demagnetization is still pending. The request must then be withheld for an arbitrary time and released on exactly the edge after demag_done_i rises. The bench reaches this state by issuing a cycle strobe with demag_done_i low, running well past 4000 cycles, and confirming silence. It then raises the flag on a chosen negative edge and checks that the request follows one sample later. The skip-release latency is reached in a similar way. The bench enters skip with every other request source active, then raises feedback across the upper threshold and times the clamp from that edge.

// File: rtl/llp_pkg.sv
package llp_pkg;
  // dead time in clock cycles for a feedback level in mV
  function automatic int dead_cycles(input int fb_mv, input int knee_mv,
                                     input int base_cyc, input int slope_cyc,
                                     input int cap_cyc);
    int d;
    if (fb_mv >= knee_mv) d = base_cyc;
    else d = base_cyc + slope_cyc * (knee_mv - fb_mv);
    if (d > cap_cyc) d = cap_cyc;
    return d;
  endfunction
endpackage

// File: rtl/llp_skip_gate.sv
module llp_skip_gate #(
  parameter int FB_W     = 12,
  parameter int ENTER_MV = 400,
  parameter int EXIT_MV  = 450
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] fb_mv_i,
  output logic            skip_o
);
  logic skip_q;
  logic below, above;

  assign below = int'(fb_mv_i) < ENTER_MV;
  assign above = int'(fb_mv_i) > EXIT_MV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              skip_q <= 1'b0;
    else if (!skip_q && below) skip_q <= 1'b1;
    else if (skip_q && above)  skip_q <= 1'b0;
  end

  assign skip_o = skip_q;

  assert_skip_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!skip_o && int'(fb_mv_i) < ENTER_MV) |=> skip_o);
  assert_skip_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && int'(fb_mv_i) <= EXIT_MV) |=> skip_o);
endmodule

// File: rtl/llp_period_timer.sv
module llp_period_timer #(
  parameter int MAX_CYC = 4000,
  localparam int CNT_W  = $clog2(MAX_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_CYC);
  logic [CNT_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tmr_q <= '0;
    else if (clear_i)        tmr_q <= '0;
    else if (tmr_q != LIMIT) tmr_q <= tmr_q + 1'b1;
  end

  assign expired_o = (tmr_q == LIMIT);

  assert_timer_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !expired_o);
endmodule

// File: rtl/llp_dead_time.sv
module llp_dead_time #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             cancel_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // load wins over cancel; hit when one cycle remains so the registered request lands on count zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (cancel_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q <= 1) run_q <= 1'b0;
    end
  end

  assign hit_o = run_q && (cnt_q == 1);

  assert_hit_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !load_i) |=> !hit_o);
endmodule

// File: rtl/llp_ctrl.sv
module llp_ctrl #(
  parameter int FB_W           = 12,
  parameter int KNEE_MV        = 800,
  parameter int DT_BASE_CYC    = 200,
  parameter int DT_SLOPE_CYC   = 10,
  parameter int PERIOD_MAX_CYC = 4000,
  parameter int SKIP_ENTER_MV  = 400,
  parameter int SKIP_EXIT_MV   = 450
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] fb_mv_i,
  input  logic            ff_mode_i,
  input  logic            valley6_i,
  input  logic            demag_done_i,
  input  logic            cycle_start_i,
  output logic            start_req_o,
  output logic            skip_o
);
  import llp_pkg::*;

  localparam int CNT_W = $clog2(PERIOD_MAX_CYC + 1);

  logic             skip;
  logic             expired;
  logic             dt_hit;
  logic             dt_load;
  logic             dt_cancel;
  logic [CNT_W-1:0] dt_val;
  logic             req_c;
  logic             req_q;
  logic             sent_q;

  llp_skip_gate #(
    .FB_W(FB_W), .ENTER_MV(SKIP_ENTER_MV), .EXIT_MV(SKIP_EXIT_MV)
  ) u_skip (
    .clk_i(clk_i), .rst_ni(rst_ni), .fb_mv_i(fb_mv_i), .skip_o(skip)
  );

  llp_period_timer #(.MAX_CYC(PERIOD_MAX_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(cycle_start_i || skip),
    .expired_o(expired)
  );

  assign dt_val    = CNT_W'(dead_cycles(int'(fb_mv_i), KNEE_MV, DT_BASE_CYC,
                                        DT_SLOPE_CYC, PERIOD_MAX_CYC));
  assign dt_load   = valley6_i && ff_mode_i && !skip;
  assign dt_cancel = cycle_start_i || skip || !ff_mode_i;

  llp_dead_time #(.CNT_W(CNT_W)) u_dead (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(dt_load), .load_val_i(dt_val), .cancel_i(dt_cancel),
    .hit_o(dt_hit)
  );

  // clamp only after demagnetization; one request per period
  assign req_c = !skip && !sent_q && !cycle_start_i &&
                 (dt_hit || (expired && demag_done_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      req_q <= req_c;
      if (cycle_start_i || skip) sent_q <= 1'b0;
      else if (req_c)            sent_q <= 1'b1;
    end
  end

  assign start_req_o = req_q;
  assign skip_o      = skip;

  assert_skip_blocks_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && $past(skip_o)) |-> !start_req_o);
  assert_req_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |=> !start_req_o);
  assert_clamp_waits_demag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired && !demag_done_i && !dt_hit) |=> !start_req_o);
  assert_no_ff_no_dead_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ff_mode_i && !expired) |=> !start_req_o);
endmodule

// File: tb/llp_ctrl_tb_top.sv
`timescale 1ns/1ps
module llp_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] fb_mv_i = 12'd900;
  logic        ff_mode_i = 1'b0;
  logic        valley6_i = 1'b0;
  logic        demag_done_i = 1'b0;
  logic        cycle_start_i = 1'b0;
  logic        start_req_o;
  logic        skip_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk_i = ~clk_i;

  llp_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fb_mv_i(fb_mv_i), .ff_mode_i(ff_mode_i),
    .valley6_i(valley6_i), .demag_done_i(demag_done_i),
    .cycle_start_i(cycle_start_i), .start_req_o(start_req_o), .skip_o(skip_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // caller stands at the negedge after the reference edge; returns edges until request, -1 if none
  task automatic wait_req(input int limit, output int lat);
    lat = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk_i);
      if (start_req_o) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic strobe_start();
    cycle_start_i = 1'b1;
    @(negedge clk_i);
    cycle_start_i = 1'b0;
  endtask

  task automatic valley_at(input int fb, output int lat);
    strobe_start();
    fb_mv_i   = 12'(fb);
    valley6_i = 1'b1;
    @(negedge clk_i);
    valley6_i = 1'b0;
    wait_req(4500, lat);
  endtask

  task automatic t_reset();
    chk("R1 start_req after reset", int'(start_req_o), 0);
    chk("R1 skip after reset", int'(skip_o), 0);
  endtask

  task automatic t_dead_nominal();
    int lat;
    ff_mode_i = 1'b1;
    demag_done_i = 1'b0;
    valley_at(900, lat);
    chk("R5 dead time at 900 mV", lat, 200);
    @(negedge clk_i);
    chk("R10 request is one cycle", int'(start_req_o), 0);
    wait_req(1000, lat);
    chk("R10 no second request in period", lat, -1);
    valley_at(800, lat);
    chk("R5 dead time at 800 mV", lat, 200);
  endtask

  task automatic t_dead_slope();
    int lat;
    ff_mode_i = 1'b1;
    demag_done_i = 1'b0;
    valley_at(700, lat);
    chk("R6 dead time at 700 mV", lat, 1200);
    valley_at(500, lat);
    chk("R6 dead time at 500 mV", lat, 3200);
    valley_at(420, lat);
    chk("R6 dead time capped at 420 mV", lat, 4000);
  endtask

  task automatic t_no_ff();
    int lat;
    ff_mode_i = 1'b0;
    demag_done_i = 1'b0;
    valley_at(900, lat);
    chk("R7 valley ignored outside foldback", lat, -1);
  endtask

  task automatic t_clamp();
    int lat;
    ff_mode_i = 1'b0;
    fb_mv_i = 12'd900;
    demag_done_i = 1'b1;
    cycle_start_i = 1'b1;
    @(negedge clk_i);
    cycle_start_i = 1'b0;
    wait_req(4500, lat);
    chk("R8 clamp after 4000 idle cycles", lat, 4001);
  endtask

  task automatic t_clamp_demag();
    int lat;
    ff_mode_i = 1'b0;
    demag_done_i = 1'b0;
    strobe_start();
    wait_req(4600, lat);
    chk("R9 clamp withheld before demag", lat, -1);
    demag_done_i = 1'b1;
    @(negedge clk_i);
    chk("R9 clamp the edge after demag", int'(start_req_o), 1);
    demag_done_i = 1'b0;
  endtask

  task automatic t_cancel();
    int lat;
    ff_mode_i = 1'b1;
    demag_done_i = 1'b0;
    strobe_start();
    fb_mv_i = 12'd700;
    valley6_i = 1'b1;
    @(negedge clk_i);
    valley6_i = 1'b0;
    repeat (100) @(negedge clk_i);
    strobe_start();
    wait_req(1500, lat);
    chk("R11 strobe cancels dead time", lat, -1);
    ff_mode_i = 1'b0;
    demag_done_i = 1'b1;
    repeat (1000) @(negedge clk_i);
    cycle_start_i = 1'b1;
    @(negedge clk_i);
    cycle_start_i = 1'b0;
    wait_req(4500, lat);
    chk("R11 strobe restarts period timer", lat, 4001);
    demag_done_i = 1'b0;
  endtask

  task automatic t_skip();
    int lat;
    ff_mode_i = 1'b0;
    fb_mv_i = 12'd400;
    @(negedge clk_i);
    chk("R2 400 mV does not enter skip", int'(skip_o), 0);
    fb_mv_i = 12'd399;
    @(negedge clk_i);
    chk("R2 below 400 mV enters skip", int'(skip_o), 1);
    fb_mv_i = 12'd450;
    repeat (3) @(negedge clk_i);
    chk("R3 450 mV holds skip", int'(skip_o), 1);
    ff_mode_i = 1'b1;
    demag_done_i = 1'b1;
    valley6_i = 1'b1;
    @(negedge clk_i);
    valley6_i = 1'b0;
    wait_req(5000, lat);
    chk("R4 no request while skipping", lat, -1);
    chk("R3 skip still held", int'(skip_o), 1);
    ff_mode_i = 1'b0;
    fb_mv_i = 12'd451;
    @(negedge clk_i);
    chk("R3 above 450 mV exits skip", int'(skip_o), 0);
    wait_req(4500, lat);
    chk("R4 timer held during skip", lat, 4001);
    demag_done_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_dead_nominal();
    t_dead_slope();
    t_no_ff();
    t_clamp();
    t_clamp_demag();
    t_cancel();
    t_skip();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule